// File: doc/BRIEF.md
# Timestamp Resequencing Output Multiplexor

This block sits at one output port of a switch built from K slower parallel layers. Each layer hands over cells for this port at a fraction of the line rate, and each layer delays cells by a different amount. Cells can therefore reach the port out of the order in which they entered the switch. Every cell carries the slot number in which it first arrived. The block restores that order and sends cells out at up to one per slot.

Each layer feeds a small FIFO of its own. Cells within one layer are already in timestamp order, so the layer FIFOs also serve as the resequencing store. Each cycle the block looks at the head of every non-empty FIFO and picks the oldest head, measuring age modulo the timestamp width against a free-running slot counter. It releases that cell when the cell has waited the full hold bound. It releases it sooner when every layer holds a cell, because no older cell can still be in flight. The slot counter is also brought out, so the upstream stamping logic and this block share one time base.

Top module: `cell_reseq`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_vld` and `full` are 0 and `slot` is 0.
- R2: `slot` increases by one every clock cycle and wraps modulo 2^TW.
- R3: If not every layer holds a cell, a cell with timestamp T is presented in the cycle where `slot` − T equals HOLD, taken modulo 2^TW.
- R4: Across all layers, cells leave in strictly increasing timestamp order (modular comparison), whatever order they arrived in.
- R5: When every layer FIFO is non-empty, the oldest head is presented two cycles after the push that filled the last empty layer, before its hold bound expires.
- R6: At most one cell leaves per cycle. Every accepted cell leaves exactly once, with its timestamp and data unchanged. No cell leaves more than HOLD slots after its timestamp.
- R7: `full` is 1 while any layer FIFO holds QD cells. A cell offered to a full layer FIFO is discarded and never appears at the output.
- R8: In a cycle with `out_vld` low, `out_ts` and `out_data` are 0.
- R9: Ordering and hold timing stay correct while the slot counter and the timestamps wrap past 2^TW − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | K | Per-layer cell strobe |
| in_ts | input | K*TW | Per-layer arrival timestamp, layer i at bits [i*TW +: TW] |
| in_data | input | K*DW | Per-layer cell payload, layer i at bits [i*DW +: DW] |
| out_vld | output | 1 | A cell is presented this cycle |
| out_ts | output | TW | Timestamp of the presented cell |
| out_data | output | DW | Payload of the presented cell |
| full | output | 1 | Some layer FIFO is full |
| slot | output | TW | Free-running slot counter used as the time base |

## Verification
The hardest situation to reach is early release. It needs every layer to hold a cell at the same moment, while the oldest of those cells sits on a layer other than the one that delivered last. The stimulus therefore pushes three cells with descending timestamps onto the three layers in a single cycle, and it expects the oldest cell to appear long before its hold bound. A long randomized phase then deals consecutive slots round-robin to the layers with random per-layer delays. This phase crosses the timestamp wrap several times and reaches the all-layers-busy case by chance, while a scoreboard checks order, payload and delay.

// File: rtl/cell_reseq.sv
module cell_reseq #(
  parameter int K    = 3,
  parameter int TW   = 8,
  parameter int DW   = 16,
  parameter int QD   = 4,
  parameter int HOLD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [K-1:0]    in_vld,
  input  logic [K*TW-1:0] in_ts,
  input  logic [K*DW-1:0] in_data,
  output logic            out_vld,
  output logic [TW-1:0]   out_ts,
  output logic [DW-1:0]   out_data,
  output logic            full,
  output logic [TW-1:0]   slot
);
  localparam int AW = (QD > 1) ? $clog2(QD) : 1;
  localparam int CW = $clog2(QD + 1);
  localparam int LW = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0]    ne, fl;
  logic [TW-1:0]   hd_ts [K];
  logic [DW-1:0]   hd_dt [K];
  logic [LW-1:0]   sel;
  logic [TW-1:0]   best_age;
  logic            rel;

  for (genvar i = 0; i < K; i++) begin : g_lane
    logic [TW-1:0] m_ts [QD];
    logic [DW-1:0] m_dt [QD];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign ne[i]    = (cnt != '0);
    assign fl[i]    = (cnt == CW'(QD));
    assign push     = in_vld[i] && !fl[i];
    assign pop      = rel && (sel == LW'(i));
    assign hd_ts[i] = m_ts[rp];
    assign hd_dt[i] = m_dt[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          m_ts[wp] <= in_ts[i*TW +: TW];
          m_dt[wp] <= in_data[i*DW +: DW];
          wp <= (wp == AW'(QD - 1)) ? '0 : wp + 1'b1;
        end
        if (pop) rp <= (rp == AW'(QD - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end
  end

  always_comb begin
    logic [TW-1:0] a;
    logic          found;
    sel      = '0;
    best_age = '0;
    found    = 1'b0;
    for (int i = 0; i < K; i++) begin
      a = slot - hd_ts[i];
      if (ne[i] && (!found || a > best_age)) begin
        sel      = LW'(i);
        best_age = a;
        found    = 1'b1;
      end
    end
  end

  assign rel  = (|ne) && ((best_age >= TW'(HOLD - 1)) || (&ne));
  assign full = |fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      out_vld  <= 1'b0;
      out_ts   <= '0;
      out_data <= '0;
    end else begin
      slot     <= slot + 1'b1;
      out_vld  <= rel;
      out_ts   <= rel ? hd_ts[sel] : '0;
      out_data <= rel ? hd_dt[sel] : '0;
    end
  end
endmodule

// File: rtl/cell_reseq_chk.sv
module cell_reseq_chk #(
  parameter int K    = 3,
  parameter int TW   = 8,
  parameter int DW   = 16,
  parameter int HOLD = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_vld,
  input logic [TW-1:0] out_ts,
  input logic [DW-1:0] out_data,
  input logic [TW-1:0] slot,
  input logic [K-1:0]  ne
);
  logic [TW-1:0] last_ts;
  logic          have_last;
  logic [5:0]    gap;
  logic [TW-1:0] dts, age;

  assign dts = out_ts - last_ts;
  assign age = slot - out_ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ts   <= '0;
      have_last <= 1'b0;
      gap       <= '0;
    end else if (out_vld) begin
      last_ts   <= out_ts;
      have_last <= 1'b1;
      gap       <= '0;
    end else if (gap == 6'd63) begin
      have_last <= 1'b0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && have_last) |-> (dts != '0 && !dts[TW-1]));

  p_delay_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (age != '0 && age <= TW'(HOLD)));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_ts == '0 && out_data == '0));

  p_from_queue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(|ne));

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slot == TW'($past(slot) + 1'b1));
endmodule

bind cell_reseq cell_reseq_chk #(.K(K), .TW(TW), .DW(DW), .HOLD(HOLD)) u_chk (.*);

// File: tb/sim_cell_reseq.sv
module sim_cell_reseq;
  localparam int K = 3, TW = 8, DW = 16, QD = 4, HOLD = 8;
  localparam int NG = 600, NS = 640;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [K-1:0]    in_vld = '0;
  logic [K*TW-1:0] in_ts = '0;
  logic [K*DW-1:0] in_data = '0;
  logic            out_vld, full;
  logic [TW-1:0]   out_ts, slot;
  logic [DW-1:0]   out_data;

  cell_reseq #(.K(K), .TW(TW), .DW(DW), .QD(QD), .HOLD(HOLD)) u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit run = 0, done = 0;
  logic [TW-1:0] q_ts[$];
  logic [DW-1:0] q_dt[$];
  int            q_age[$];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_cell(logic [TW-1:0] ts, logic [DW-1:0] d, int age);
    q_ts.push_back(ts);
    q_dt.push_back(d);
    q_age.push_back(age);
  endtask

  task automatic put(int l, logic [TW-1:0] ts, logic [DW-1:0] d);
    in_vld[l] = 1'b1;
    in_ts[l*TW +: TW] = ts;
    in_data[l*DW +: DW] = d;
  endtask

  task automatic step();
    @(negedge clk);
    in_vld = '0;
  endtask

  // scoreboard monitor: order, payload, delay (R3 R4 R5 R6 R8 R9)
  always @(negedge clk) begin
    if (run) begin
      if (out_vld) begin
        if (q_ts.size() == 0) begin
          chk(0, "R6 unexpected cell", int'(out_ts), -1);
        end else begin
          logic [TW-1:0] ets, age;
          logic [DW-1:0] ed;
          int ea;
          ets = q_ts.pop_front();
          ed  = q_dt.pop_front();
          ea  = q_age.pop_front();
          age = slot - out_ts;
          chk(out_ts == ets, "R4 ts order", int'(out_ts), int'(ets));
          chk(out_data == ed, "R6 payload", int'(out_data), int'(ed));
          if (ea >= 0) chk(int'(age) == ea, "R3/R5 release age", int'(age), ea);
          else chk(age >= 1 && age <= HOLD, "R6 delay bound", int'(age), HOLD);
        end
      end else begin
        chk(out_ts == '0 && out_data == '0, "R8 idle zero", int'(out_data), 0);
      end
    end
  end

  initial begin
    repeat (2000 + NS * 2) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] s, prev;
    bit            sv [K][NS];
    logic [TW-1:0] sts[K][NS];
    logic [DW-1:0] sdt[K][NS];
    int            last[K];
    int            rr, d;
    logic [DW-1:0] seq;

    repeat (3) @(negedge clk);
    chk(out_vld == 0 && full == 0 && slot == 0, "R1 in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 0 && full == 0 && slot == 1, "R1 after reset", int'(slot), 1);
    prev = slot;
    step();
    chk(slot == prev + 1'b1, "R2 slot step", int'(slot), int'(prev) + 1);
    run = 1;

    // R3: lone cell, exact hold
    s = slot;
    expect_cell(s, 16'h1111, HOLD);
    put(1, s, 16'h1111);
    step();
    repeat (HOLD + 2) step();

    // R4: arrivals out of order across two layers
    s = slot;
    expect_cell(s - 8'd2, 16'h2222, HOLD);
    expect_cell(s, 16'h2223, HOLD);
    put(0, s, 16'h2223);
    put(1, s - 8'd2, 16'h2222);
    step();
    repeat (HOLD + 2) step();

    // R5: every layer occupied -> oldest leaves early
    s = slot;
    expect_cell(s - 8'd2, 16'h3330, 4);
    expect_cell(s - 8'd1, 16'h3331, HOLD);
    expect_cell(s, 16'h3332, HOLD);
    put(0, s, 16'h3332);
    put(1, s - 8'd1, 16'h3331);
    put(2, s - 8'd2, 16'h3330);
    step();
    repeat (HOLD + 2) step();

    // R7: fill one layer, overflow cell is dropped
    s = slot;
    for (int i = 0; i < QD; i++) begin
      expect_cell(s + 8'(i), 16'h4440 + 16'(i), HOLD);
      put(0, s + 8'(i), 16'h4440 + 16'(i));
      step();
    end
    chk(full == 1, "R7 full set", int'(full), 1);
    put(0, slot, 16'hDEAD);
    step();
    chk(full == 1, "R7 full held", int'(full), 1);
    repeat (HOLD + 3) step();
    chk(full == 0, "R7 full clear", int'(full), 0);
    chk(q_ts.size() == 0, "R6 all delivered", q_ts.size(), 0);

    // R9: long random stream across several timestamp wraps
    for (int l = 0; l < K; l++) begin
      last[l] = -1;
      for (int j = 0; j < NS; j++) sv[l][j] = 0;
    end
    s = slot;
    rr = 0;
    seq = 16'h8000;
    for (int j = 0; j < NG; j++) begin
      if ($urandom % 5 != 0) begin
        d = j + int'($urandom % 4);
        if (d <= last[rr]) d = last[rr] + 1;
        last[rr] = d;
        sv[rr][d] = 1;
        sts[rr][d] = s + 8'(j);
        sdt[rr][d] = seq;
        expect_cell(s + 8'(j), seq, -1);
        seq++;
        rr = (rr + 1) % K;
      end
    end
    for (int j = 0; j < NS; j++) begin
      for (int l = 0; l < K; l++)
        if (sv[l][j]) put(l, sts[l][j], sdt[l][j]);
      step();
    end
    repeat (HOLD + 4) step();
    chk(q_ts.size() == 0, "R9 random stream drained", q_ts.size(), 0);
    chk(full == 0, "R7 no full in stream", int'(full), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule